// File: doc/BRIEF.md
# Interrupt Source PQ Coalescer

This block keeps a two-bit event state for each source in a small array of interrupt sources. The first bit, P, means a notification has gone out and is waiting for an end-of-interrupt (EOI). The second bit, Q, means another trigger arrived while P was set. A one-cycle trigger pulse for a source either sends that source's number to a single downstream event-queue port, or records the trigger in the state for later. A source therefore sits in the queue at most once. Software controls each source through a 4 KB page of a load/store port. The page is chosen by the upper address bits. Special offsets within the page read the state, force it, or perform an EOI. Every load returns the state as it was before the access.

An EOI that finds Q set re-arms the source and sends a new notification in the same operation. When several sources need to send at once, a fixed-priority arbiter orders them and the others wait. The notification port is a valid/ready handshake that holds its data while it waits for ready. Reset leaves every source masked, so nothing is sent until software enables a source.

Top module: `pq_coalesce_ctrl`

## Requirements
- R1: After reset every source holds PQ=01, `note_valid` is 0 and `rsp_valid` is 0.
- R2: A load at page offset 0x800 returns the source's PQ in `rsp_data` and leaves the state unchanged. P is in bit 1 and Q is in bit 0; all other bits are 0.
- R3: A load at offset 0xC00, 0xD00, 0xE00 or 0xF00 returns the old PQ. It then sets PQ to 00, 01, 10 or 11 respectively, taken from offset bits 9:8.
- R4: A load at offset 0x000 is an EOI and returns the old PQ. If Q was 0 the state becomes 00 and nothing is sent. If Q was 1 the state becomes 10 and a notification for that source is queued.
- R5: A store at offset 0x400 is an EOI with the same effect as R4, but only on pages whose bit in `STORE_EOI_MASK` is 1. On other pages, and at any other store offset, a store has no effect.
- R6: A trigger pulse changes the state as follows: 00 becomes 10 and queues a notification; 10 becomes 11; 11 stays 11; 01 stays 01 (masked). Only the first case queues anything. With no access and no trigger, the state does not change.
- R7: A load at any offset other than those in R2–R4, or to a page number ≥ NSRC, returns all ones and changes no state.
- R8: A queued notification appears on `note_valid`/`note_src` in the cycle after the event that queued it, if the port is free. It holds its value until `note_ready`. When several sources are waiting, the lowest source number goes first.
- R9: When an access and a trigger hit the same source in the same cycle, the access is applied first and the trigger acts on its result. The load returns the state from before both.
- R10: `rsp_valid` pulses exactly one cycle after each accepted load and never after a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | NSRC | One-cycle trigger pulse per source |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 12+SRC_W | Page number (upper bits) and page offset (low 12 bits) |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | 64 | Prior PQ value or all ones |
| note_valid | output | 1 | Notification available |
| note_ready | input | 1 | Downstream accepts notification |
| note_src | output | SRC_W | Source number of the notification |

## Verification
The bench builds the block with NSRC=5 and STORE_EOI_MASK=5'b00101. With 5 sources, the three-bit page field has three unused page numbers, so the all-ones response for out-of-range pages can be reached. The mask lets store EOIs be compared on an enabled page (0) and a disabled page (1). With three waiting sources and the ready signal held low, the bench can observe priority order and hold stability. Same-cycle access and trigger on source 2 exercise the order in which the two are applied.

// File: rtl/pq_pkg.sv
// Package: shared constants and types for the PQ coalescer.
// Assumes 4 KB pages and 64-bit load data.
package pq_pkg;
    localparam int PAGE_BITS = 12;
    localparam int DATA_W    = 64;

    typedef logic [1:0] pq_t;

    localparam pq_t PQ_IDLE    = 2'b00;
    localparam pq_t PQ_MASKED  = 2'b01;
    localparam pq_t PQ_PENDING = 2'b10;
    localparam pq_t PQ_QUEUED  = 2'b11;

    localparam logic [PAGE_BITS-1:0] OFS_EOI_LOAD  = 12'h000;
    localparam logic [PAGE_BITS-1:0] OFS_EOI_STORE = 12'h400;
    localparam logic [PAGE_BITS-1:0] OFS_GET       = 12'h800;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_GET,
        OP_EOI,
        OP_SET
    } pq_op_e;
endpackage

// File: rtl/pq_mmio_decode.sv
// Module: address decoder. Splits the address into page and offset
// and produces a one-hot source select plus the operation.
// Assumes ADDR_W == PAGE_BITS + SRC_W. Pages >= NSRC select nothing.
module pq_mmio_decode
    import pq_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int SRC_W = 3,
    parameter int ADDR_W = 15,
    parameter logic [NSRC-1:0] STORE_EOI_MASK = '1
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [NSRC-1:0]   sel,
    output pq_op_e            op,
    output pq_t               set_val,
    output logic              load_defined
);
    logic [SRC_W-1:0]     page;
    logic [PAGE_BITS-1:0] ofs;
    logic [NSRC-1:0]      page_hit;
    logic                 in_range;
    logic                 store_ok;

    assign page = req_addr[ADDR_W-1 -: SRC_W];
    assign ofs  = req_addr[PAGE_BITS-1:0];

    // One comparator per existing source page.
    for (genvar i = 0; i < NSRC; i++) begin : g_hit
        assign page_hit[i] = (page == SRC_W'(i));
    end

    assign in_range = |page_hit;
    assign store_ok = |(page_hit & STORE_EOI_MASK);

    // Offset decode: map the access to an operation.
    always_comb begin
        op      = OP_NONE;
        set_val = ofs[9:8];
        if (req_valid && in_range) begin
            if (req_write) begin
                if (ofs == OFS_EOI_STORE && store_ok) op = OP_EOI;
            end else if (ofs == OFS_EOI_LOAD) begin
                op = OP_EOI;
            end else if (ofs == OFS_GET) begin
                op = OP_GET;
            end else if (ofs[11:10] == 2'b11 && ofs[7:0] == 8'h00) begin
                op = OP_SET;
            end
        end
    end

    assign sel          = (op == OP_NONE) ? '0 : page_hit;
    assign load_defined = (op != OP_NONE) && !req_write;
endmodule

// File: rtl/pq_src_cell.sv
// Module: state of one source. Applies the access first, then the
// trigger to the result, within one cycle. Raises notify when either
// step asks for a notification. Reset state is masked (01).
module pq_src_cell
    import pq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sel,
    input  pq_op_e op,
    input  pq_t    set_val,
    input  logic   trig,
    output pq_t    pq_q,
    output logic   notify
);
    pq_t  mid, nxt;
    logic n_access, n_trig;

    // Access step: EOI or forced value.
    always_comb begin
        mid      = pq_q;
        n_access = 1'b0;
        if (sel) begin
            case (op)
                OP_EOI: begin
                    if (pq_q[0]) begin
                        mid      = PQ_PENDING;
                        n_access = 1'b1;
                    end else begin
                        mid = PQ_IDLE;
                    end
                end
                OP_SET:  mid = set_val;
                default: mid = pq_q;
            endcase
        end
    end

    // Trigger step: acts on the state left by the access step.
    always_comb begin
        nxt    = mid;
        n_trig = 1'b0;
        if (trig) begin
            case (mid)
                PQ_IDLE: begin
                    nxt    = PQ_PENDING;
                    n_trig = 1'b1;
                end
                PQ_PENDING: nxt = PQ_QUEUED;
                default:    nxt = mid;
            endcase
        end
    end

    assign notify = n_access | n_trig;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) pq_q <= PQ_MASKED;
        else        pq_q <= nxt;
    end
endmodule

// File: rtl/pq_prio_arb.sv
// Module: notification arbiter and output stage. Holds one waiting bit
// per source. When the output register is free, it loads the lowest
// numbered source among the waiting bits and this cycle's new requests.
// The output holds until ready.
module pq_prio_arb #(
    parameter int N = 8,
    parameter int IDW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   new_req,
    input  logic           note_ready,
    output logic           note_valid,
    output logic [IDW-1:0] note_src
);
    logic [N-1:0]   pend_q, cand, win_oh;
    logic [IDW-1:0] win_idx;
    logic           any, out_free;

    assign cand     = pend_q | new_req;
    assign out_free = !note_valid || note_ready;

    // Lowest index wins: scan downward so the last match is the lowest.
    always_comb begin
        win_idx = '0;
        win_oh  = '0;
        any     = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                win_idx    = IDW'(i);
                win_oh     = '0;
                win_oh[i]  = 1'b1;
                any        = 1'b1;
            end
        end
    end

    // Waiting bits and the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            note_valid <= 1'b0;
            note_src   <= '0;
        end else if (out_free) begin
            note_valid <= any;
            if (any) note_src <= win_idx;
            pend_q <= cand & ~win_oh;
        end else begin
            pend_q <= cand;
        end
    end
endmodule

// File: rtl/pq_coalesce_ctrl.sv
// Module: top of the PQ coalescer. Holds one state cell per source,
// the address decoder, the notification arbiter and a registered load
// response (one cycle of latency).
// Assumes at most one access per cycle; stores return no data.
module pq_coalesce_ctrl
    import pq_pkg::*;
#(
    parameter int NSRC = 8,
    parameter logic [NSRC-1:0] STORE_EOI_MASK = '1,
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int ADDR_W = PAGE_BITS + SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   trig,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              note_valid,
    input  logic              note_ready,
    output logic [SRC_W-1:0]  note_src
);
    logic [NSRC-1:0]   sel;
    pq_op_e            op;
    pq_t               set_val;
    logic              load_defined;
    pq_t               src_pq [NSRC];
    logic [NSRC-1:0]   notify;
    logic [2*NSRC-1:0] state_flat;
    pq_t               old_pq;

    pq_mmio_decode #(
        .NSRC(NSRC), .SRC_W(SRC_W), .ADDR_W(ADDR_W),
        .STORE_EOI_MASK(STORE_EOI_MASK)
    ) u_dec (
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .sel(sel), .op(op), .set_val(set_val), .load_defined(load_defined)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        pq_src_cell u_cell (
            .clk(clk), .rst_n(rst_n), .sel(sel[i]), .op(op),
            .set_val(set_val), .trig(trig[i]),
            .pq_q(src_pq[i]), .notify(notify[i])
        );
        assign state_flat[2*i +: 2] = src_pq[i];
    end

    pq_prio_arb #(.N(NSRC), .IDW(SRC_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .new_req(notify),
        .note_ready(note_ready), .note_valid(note_valid), .note_src(note_src)
    );

    // Prior state of the selected source (one-hot OR mux).
    always_comb begin
        old_pq = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel[i]) old_pq = old_pq | src_pq[i];
        end
    end

    // Load response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_data  <= load_defined ? {{(DATA_W-2){1'b0}}, old_pq} : '1;
        end
    end
endmodule

// File: rtl/pq_coalesce_ctrl_chk.sv
// Module: property checker bound to pq_coalesce_ctrl. Watches the
// ports and the flattened source state.
module pq_coalesce_ctrl_chk #(
    parameter int NSRC = 8,
    parameter int SRC_W = 3,
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   trig,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [63:0]       rsp_data,
    input logic              note_valid,
    input logic              note_ready,
    input logic [SRC_W-1:0]  note_src,
    input logic [2*NSRC-1:0] state_flat
);
    logic [11:0] ofs;
    logic        ofs_known;
    assign ofs       = req_addr[11:0];
    assign ofs_known = (ofs == 12'h000) || (ofs == 12'h800) ||
                       (ofs[11:10] == 2'b11 && ofs[7:0] == 8'h00);

    AST_LOAD_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> rsp_valid); // R10
    AST_NO_STORE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |=> !rsp_valid); // R10
    AST_NOTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        note_valid && !note_ready |=> note_valid && $stable(note_src)); // R8
    AST_NOTE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        note_valid |-> int'(note_src) < NSRC); // R8
    AST_QUIET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid && trig == '0 |=> $stable(state_flat)); // R6
    AST_GET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && ofs == 12'h800 && trig == '0
        |=> $stable(state_flat)); // R2
    AST_BAD_OFS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && !ofs_known |=> rsp_data == '1); // R7
endmodule

bind pq_coalesce_ctrl pq_coalesce_ctrl_chk #(
    .NSRC(NSRC), .SRC_W(SRC_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .trig(trig), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .note_valid(note_valid), .note_ready(note_ready),
    .note_src(note_src), .state_flat(state_flat)
);

// File: tb/pq_coalesce_ctrl_test.sv
`timescale 1ns/1ps
module pq_coalesce_ctrl_test;
    localparam int NSRC = 5;
    localparam int SRC_W = 3;
    localparam int ADDR_W = 15;
    localparam logic [63:0] ONES = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   trig = '0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid;
    logic [63:0]       rsp_data;
    logic              note_valid;
    logic              note_ready = 1'b0;
    logic [SRC_W-1:0]  note_src;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pq_coalesce_ctrl #(.NSRC(NSRC), .STORE_EOI_MASK(5'b00101)) uut (
        .clk(clk), .rst_n(rst_n), .trig(trig), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .note_valid(note_valid), .note_ready(note_ready),
        .note_src(note_src)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] addr(input int src, input logic [11:0] ofs);
        return {SRC_W'(src), ofs};
    endfunction

    // One cycle of stimulus (called at a negedge); samples at the next negedge.
    task automatic cycle(input logic v, input logic wr, input logic [ADDR_W-1:0] a,
                         input logic [NSRC-1:0] t, output logic [63:0] d, output logic rv);
        req_valid = v; req_write = wr; req_addr = a; trig = t;
        @(negedge clk);
        d = rsp_data; rv = rsp_valid;
        req_valid = 1'b0; req_write = 1'b0; trig = '0;
    endtask

    task automatic load(input int src, input logic [11:0] ofs, output logic [63:0] d);
        logic rv;
        cycle(1'b1, 1'b0, addr(src, ofs), '0, d, rv);
        check("R10 rsp_valid after load", 64'(rv), 64'd1);
    endtask

    task automatic get_pq(input int src, output logic [63:0] d);
        load(src, 12'h800, d);
    endtask

    task automatic pulse(input logic [NSRC-1:0] t);
        logic [63:0] d; logic rv;
        cycle(1'b0, 1'b0, '0, t, d, rv);
    endtask

    task automatic pop(input string req, input int exp_src);
        check(req, {63'd0, note_valid}, 64'd1);
        check(req, 64'(note_src), 64'(exp_src));
        note_ready = 1'b1;
        @(negedge clk);
        note_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] d;
        check("R1 note_valid after reset", 64'(note_valid), 64'd0);
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        for (int s = 0; s < NSRC; s++) begin
            get_pq(s, d);
            check("R1 reset PQ=01", d, 64'd1);
        end
    endtask

    task automatic t_get_set();
        logic [63:0] d;
        get_pq(2, d);
        get_pq(2, d);
        check("R2 get leaves state", d, 64'd1);
        load(2, 12'hF00, d); check("R3 set11 returns old", d, 64'd1);
        load(2, 12'hE00, d); check("R3 setE00 returns 11", d, 64'd3);
        load(2, 12'hC00, d); check("R3 setC00 returns 10", d, 64'd2);
        load(2, 12'hD00, d); check("R3 setD00 returns 00", d, 64'd0);
        get_pq(2, d);        check("R3 state now 01", d, 64'd1);
    endtask

    task automatic t_trigger();
        logic [63:0] d;
        load(1, 12'hC00, d);
        pulse(5'b00010);
        check("R6 00 trigger notifies", 64'(note_valid), 64'd1);
        get_pq(1, d); check("R6 00->10", d, 64'd2);
        pulse(5'b00010);
        get_pq(1, d); check("R6 10->11", d, 64'd3);
        pop("R8 single notification src1", 1);
        check("R6 no second notification", 64'(note_valid), 64'd0);
        pulse(5'b00010);
        get_pq(1, d); check("R6 11 stays", d, 64'd3);
        check("R6 11 no notify", 64'(note_valid), 64'd0);
        pulse(5'b01000);
        get_pq(3, d); check("R6 masked stays 01", d, 64'd1);
        check("R6 masked no notify", 64'(note_valid), 64'd0);
    endtask

    task automatic t_eoi_load();
        logic [63:0] d;
        load(1, 12'h000, d); check("R4 eoi returns 11", d, 64'd3);
        pop("R4 eoi with Q re-sends", 1);
        get_pq(1, d); check("R4 Q=1 -> 10", d, 64'd2);
        load(1, 12'h000, d); check("R4 eoi returns 10", d, 64'd2);
        check("R4 Q=0 no notify", 64'(note_valid), 64'd0);
        get_pq(1, d); check("R4 Q=0 -> 00", d, 64'd0);
    endtask

    task automatic t_store_eoi();
        logic [63:0] d; logic rv;
        load(0, 12'hF00, d);
        cycle(1'b1, 1'b1, addr(0, 12'h400), '0, d, rv);
        check("R10 no rsp on store", 64'(rv), 64'd0);
        pop("R5 store eoi enabled page", 0);
        get_pq(0, d); check("R5 enabled page 11->10", d, 64'd2);
        load(1, 12'hF00, d);
        cycle(1'b1, 1'b1, addr(1, 12'h400), '0, d, rv);
        get_pq(1, d); check("R5 disabled page unchanged", d, 64'd3);
        check("R5 disabled page no notify", 64'(note_valid), 64'd0);
        cycle(1'b1, 1'b1, addr(0, 12'h000), '0, d, rv);
        get_pq(0, d); check("R5 other store offset ignored", d, 64'd2);
    endtask

    task automatic t_undef();
        logic [63:0] d;
        load(2, 12'h100, d); check("R7 undefined offset ones", d, ONES);
        load(2, 12'hC08, d); check("R7 near-set offset ones", d, ONES);
        get_pq(2, d);        check("R7 state unchanged", d, 64'd1);
        load(6, 12'h800, d); check("R7 page beyond NSRC ones", d, ONES);
        load(7, 12'hC00, d); check("R7 page 7 ones", d, ONES);
    endtask

    task automatic t_arb();
        logic [63:0] d;
        load(0, 12'hC00, d); load(3, 12'hC00, d); load(4, 12'hC00, d);
        pulse(5'b11001);
        check("R8 lowest first", 64'(note_src), 64'd0);
        @(negedge clk);
        check("R8 hold without ready", 64'(note_valid), 64'd1);
        check("R8 hold src", 64'(note_src), 64'd0);
        pop("R8 order 0", 0);
        pop("R8 order 3", 3);
        pop("R8 order 4", 4);
        check("R8 drained", 64'(note_valid), 64'd0);
    endtask

    task automatic t_same_cycle();
        logic [63:0] d; logic rv;
        load(2, 12'hC00, d);
        cycle(1'b1, 1'b0, addr(2, 12'hD00), 5'b00100, d, rv);
        check("R9 returns state before both", d, 64'd0);
        check("R9 mask then trigger no notify", 64'(note_valid), 64'd0);
        get_pq(2, d); check("R9 masked wins", d, 64'd1);
        load(2, 12'hE00, d);
        cycle(1'b1, 1'b0, addr(2, 12'h000), 5'b00100, d, rv);
        check("R9 eoi+trigger returns 10", d, 64'd2);
        pop("R9 eoi then trigger notifies", 2);
        get_pq(2, d); check("R9 final 10", d, 64'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_get_set();
        t_trigger();
        t_eoi_load();
        t_store_eoi();
        t_undef();
        t_arb();
        t_same_cycle();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule